// File: doc/BRIEF.md
# Byte-Level I2C Master with Status Codes

This block is a byte-level I2C master controlled through four register addresses: address 0 is the data register, address 1 is control, address 2 is status, and address 3 is soft reset. Status is read-only, so a write to address 2 has no effect. Software writes control to start a bus step. For each START, repeated START, address byte or data byte, the engine runs the bus sequence. It then raises the interrupt flag, holds SCL low and posts an 8-bit status code. Software reads the code, loads the data register when a byte is to be sent, and writes control again to pick the next step.

The control register keeps its bits in fixed positions:

| Bit | Function |
|-----|----------|
| 2 | acknowledge enable |
| 3 | interrupt flag |
| 4 | STOP request |
| 5 | START request |
| 6 | engine enable |
| 7 | interrupt enable |

SCL and SDA are open-drain. Each line has an output enable (1 pulls the line low) and a separate input that shows the level on the wire.

The first byte after a START is the address byte, and its bit 0 is the read/write bit (1 = read). A first byte of the form 11110xxR starts a 10-bit address. After that byte is acknowledged, the next byte sent is the low address byte. That byte gets its own set of status codes.

Top module: `i2cm_engine`

## Requirements
- R1: After reset the status reads 0xF8, control reads 0x00, irq_o is low and both line enables are low.
- R2: A control write with START (bit 5) and ENABLE (bit 6) both set generates a START condition and posts 0x08. START without ENABLE is ignored: no bus activity and no flag.
- R3: On an address byte with bit 0 = 0 (write), the status is 0x18 on ACK and 0x20 on NACK. With bit 0 = 1 (read), the status is 0x40 on ACK and 0x48 on NACK.
- R4: When the first address byte is 11110,a9,a8,R and is acknowledged, the next byte is taken as the second address byte. That byte posts 0xD0 on ACK or 0xD8 on NACK for a write, and 0xE0 on ACK or 0xE8 on NACK for a read.
- R5: A write data byte is shifted out MSB first and posts 0x28 on ACK or 0x30 on NACK.
- R6: A read data byte is loaded into the data register. The master returns ACK and posts 0x50 when control bit 2 was set as the byte started. Otherwise it returns NACK and posts 0x58.
- R7: Every bus event sets control bit 3. While that bit is set, SCL stays low and the status does not change. Whenever the bit is clear, the status reads 0xF8.
- R8: With iflg_w1c_i = 1, the flag is cleared only by a control write with bit 3 = 1. With iflg_w1c_i = 0, it is cleared only by a control write with bit 3 = 0. A control write with the other value leaves the flag set.
- R9: A control write with STOP (bit 4) generates a STOP condition, releases both lines and leaves the status at 0xF8 with no flag. STOP takes priority over START.
- R10: START requested while the engine holds the bus produces a repeated START and posts 0x10.
- R11: If SDA reads low while the engine releases it during a transmitted bit, the engine releases both lines at once and posts 0x38.
- R12: Any write to address 3 forces the engine idle: flag clear, control cleared, both lines released.
- R13: irq_o is high exactly when control bit 3 and bit 7 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iflg_w1c_i | input | 1 | Flag clear polarity: 1 = write one clears, 0 = write zero clears |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 data, 1 control, 2 status, 3 soft reset |
| wr_data_i | input | 8 | Register write data |
| data_o | output | 8 | Data register contents |
| ctrl_o | output | 8 | Control register contents |
| status_o | output | 8 | Status code, 0xF8 when no event is pending |
| irq_o | output | 1 | Interrupt request |
| scl_oe_o | output | 1 | Pull SCL low |
| scl_i | input | 1 | SCL line level |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
The assertions assume that software writes no register while it is waiting for a held state to persist. They also assume that scl_i follows the released SCL line within the same cycle, so the high phase never stalls forever. The stimulus keeps to both assumptions. All register writes come from single-cycle tasks issued only after the flag is seen. The bench derives the line levels as a wired-AND of the engine, a behavioural target and an arbitration forcing term, so SCL rises as soon as it is released. Random transfers vary:
- the address width,
- the direction,
- the length,
- the flag clear polarity.

Directed cases cover NACKs, arbitration, repeated START and soft reset.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {K_ADR1, K_ADR2, K_TX, K_RX} kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_A, S_STA_A, S_STA_B, S_STA_C, S_HOLD,
    S_BIT_LO, S_BIT_HI, S_STP_A, S_STP_B, S_STP_C
  } st_e;

  localparam logic [7:0] CODE_START  = 8'h08;
  localparam logic [7:0] CODE_RSTART = 8'h10;
  localparam logic [7:0] CODE_ARB    = 8'h38;
  localparam logic [7:0] CODE_NONE   = 8'hF8;

  localparam int CB_ACK  = 2;
  localparam int CB_FLAG = 3;
  localparam int CB_STOP = 4;
  localparam int CB_STA  = 5;
  localparam int CB_EN   = 6;
  localparam int CB_IE   = 7;

  function automatic logic [7:0] byte_code(kind_e k, logic rw, logic ack);
    case (k)
      K_ADR1:  return rw ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
      K_ADR2:  return rw ? (ack ? 8'hE0 : 8'hE8) : (ack ? 8'hD0 : 8'hD8);
      K_TX:    return ack ? 8'h28 : 8'h30;
      default: return ack ? 8'h50 : 8'h58;
    endcase
  endfunction

endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       iflg_w1c_i,
  input  logic       evt_i,
  input  logic [7:0] evt_code_i,
  input  logic       rx_vld_i,
  input  logic [7:0] rx_byte_i,
  input  logic       take_i,
  output logic       srst_o,
  output logic       en_o,
  output logic       ack_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       iflg_o,
  output logic [7:0] data_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic       ie_q;
  logic [7:0] code_q;
  logic       unused_bits;

  assign unused_bits = ^wr_data_i[1:0];
  assign srst_o = wr_en_i && (wr_addr_i == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {en_o, ack_o, start_o, stop_o, iflg_o, ie_q} <= '0;
      data_o <= '0;
      code_q <= CODE_NONE;
    end else if (srst_o) begin
      {en_o, ack_o, start_o, stop_o, iflg_o, ie_q} <= '0;
      code_q <= CODE_NONE;
    end else begin
      if (take_i) begin
        start_o <= 1'b0;
        stop_o  <= 1'b0;
      end
      if (wr_en_i && wr_addr_i == 2'd0) data_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd1) begin
        ack_o   <= wr_data_i[CB_ACK];
        en_o    <= wr_data_i[CB_EN];
        ie_q    <= wr_data_i[CB_IE];
        start_o <= wr_data_i[CB_STA] & wr_data_i[CB_EN];
        stop_o  <= wr_data_i[CB_STOP];
        if (wr_data_i[CB_FLAG] == iflg_w1c_i) iflg_o <= 1'b0;
      end
      // a bus event outranks a racing clear
      if (evt_i) begin
        iflg_o <= 1'b1;
        code_q <= evt_code_i;
      end
      if (rx_vld_i) data_o <= rx_byte_i;
    end
  end

  assign ctrl_o   = {ie_q, en_o, start_o, stop_o, iflg_o, ack_o, 2'b00};
  assign status_o = iflg_o ? code_q : CODE_NONE;
  assign irq_o    = iflg_o & ie_q;

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       en_i,
  input  logic       ack_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       iflg_i,
  input  logic [7:0] data_i,
  output logic       take_o,
  output logic       evt_o,
  output logic [7:0] evt_code_o,
  output logic       rx_vld_o,
  output logic [7:0] rx_byte_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       scl_i,
  input  logic       sda_i
);
  localparam int CW = $clog2(CLK_DIV) + 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  st_e           st, st_n;
  kind_e         kind, kind_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [3:0]    bitn, bit_n;
  logic [7:0]    sh, sh_n;
  logic          rw, rw_n, ten, ten_n, ackq, ackq_n, rs, rs_n;
  logic          tick, ackbit;

  always_comb begin
    st_n = st; kind_n = kind; bit_n = bitn; sh_n = sh;
    rw_n = rw; ten_n = ten; ackq_n = ackq; rs_n = rs;
    take_o = 1'b0; evt_o = 1'b0; evt_code_o = CODE_NONE; rx_vld_o = 1'b0;
    ackbit = 1'b0;
    tick  = (cnt == LAST);
    cnt_n = (st == S_BIT_HI && !scl_i) ? cnt : cnt + 1'b1;
    case (st)
      S_IDLE: begin
        if (!iflg_i && stop_i) take_o = 1'b1;
        else if (!iflg_i && start_i && en_i) begin
          take_o = 1'b1; rs_n = 1'b0; st_n = S_STA_A;
        end
      end
      S_HOLD: begin
        if (!iflg_i) begin
          if (stop_i) begin
            take_o = 1'b1; st_n = S_STP_A;
          end else if (start_i) begin
            take_o = 1'b1; rs_n = 1'b1; st_n = S_RST_A;
          end else begin
            st_n = S_BIT_LO; bit_n = '0; sh_n = data_i; ackq_n = ack_i;
            if (kind == K_ADR1) begin
              rw_n  = data_i[0];
              ten_n = (data_i[7:3] == 5'b11110);
            end
          end
        end
      end
      S_RST_A: if (tick) st_n = S_STA_A;
      S_STA_A: if (tick) st_n = S_STA_B;
      S_STA_B: if (tick) st_n = S_STA_C;
      S_STA_C: if (tick) begin
        st_n = S_HOLD; kind_n = K_ADR1;
        evt_o = 1'b1; evt_code_o = rs ? CODE_RSTART : CODE_START;
      end
      S_BIT_LO: if (tick) st_n = S_BIT_HI;
      S_BIT_HI: if (tick) begin
        if (bitn == 4'd8) begin
          ackbit     = (kind == K_RX) ? ackq : !sda_i;
          evt_o      = 1'b1;
          evt_code_o = byte_code(kind, rw, ackbit);
          rx_vld_o   = (kind == K_RX);
          st_n       = S_HOLD;
          case (kind)
            K_ADR1:  kind_n = ten ? K_ADR2 : (rw ? K_RX : K_TX);
            K_ADR2:  kind_n = rw ? K_RX : K_TX;
            default: kind_n = kind;
          endcase
        end else if (kind != K_RX && sh[7] && !sda_i) begin
          evt_o = 1'b1; evt_code_o = CODE_ARB; st_n = S_IDLE;
        end else begin
          sh_n = {sh[6:0], sda_i}; bit_n = bitn + 4'd1; st_n = S_BIT_LO;
        end
      end
      S_STP_A: if (tick) st_n = S_STP_B;
      S_STP_B: if (tick) st_n = S_STP_C;
      S_STP_C: if (tick) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (st_n != st || st == S_IDLE || st == S_HOLD) cnt_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; kind <= K_ADR1; cnt <= '0; bitn <= '0; sh <= '0;
      {rw, ten, ackq, rs} <= '0;
    end else if (srst_i) begin
      st <= S_IDLE; kind <= K_ADR1; cnt <= '0; bitn <= '0;
    end else begin
      st <= st_n; kind <= kind_n; cnt <= cnt_n; bitn <= bit_n; sh <= sh_n;
      rw <= rw_n; ten <= ten_n; ackq <= ackq_n; rs <= rs_n;
    end
  end

  assign rx_byte_o = sh;

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (st)
      S_STA_B: sda_oe_o = 1'b1;
      S_STA_C: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      S_HOLD, S_RST_A: scl_oe_o = 1'b1;
      S_STP_A: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      S_STP_B: sda_oe_o = 1'b1;
      S_BIT_LO, S_BIT_HI: begin
        scl_oe_o = (st == S_BIT_LO);
        if (kind == K_RX) sda_oe_o = (bitn == 4'd8) && ackq;
        else              sda_oe_o = (bitn != 4'd8) && !sh[7];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       iflg_w1c_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] data_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       scl_oe_o,
  input  logic       scl_i,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  logic       srst, en, ack, start, stop, iflg, take, evt, rx_vld;
  logic [7:0] evt_code, rx_byte;

  i2cm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .iflg_w1c_i,
    .evt_i(evt), .evt_code_i(evt_code), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
    .take_i(take), .srst_o(srst), .en_o(en), .ack_o(ack), .start_o(start),
    .stop_o(stop), .iflg_o(iflg), .data_o, .ctrl_o, .status_o, .irq_o
  );

  i2cm_seq #(.CLK_DIV(CLK_DIV)) u_seq (
    .clk_i, .rst_ni, .srst_i(srst), .en_i(en), .ack_i(ack), .start_i(start),
    .stop_i(stop), .iflg_i(iflg), .data_i(data_o), .take_o(take), .evt_o(evt),
    .evt_code_o(evt_code), .rx_vld_o(rx_vld), .rx_byte_o(rx_byte),
    .scl_oe_o, .sda_oe_o, .scl_i, .sda_i
  );

endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_addr_i,
  input logic [7:0] ctrl_o,
  input logic [7:0] status_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o
);
  assert_scl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3] && scl_oe_o && !wr_en_i) |=> scl_oe_o);

  assert_status_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3] && !wr_en_i) |=> (ctrl_o[3] && $stable(status_o)));

  assert_event_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[3]) |-> (status_o != 8'hF8 && status_o[2:0] == 3'b000));

  assert_arb_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_o[3]) && status_o == 8'h38) |-> (!scl_oe_o && !sda_oe_o));

  assert_soft_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> (!ctrl_o[3] && !scl_oe_o && !sda_oe_o));
endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .ctrl_o, .status_o, .scl_oe_o, .sda_oe_o
);

// File: tb/i2cm_engine_tb_top.sv
module i2cm_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, w1c = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] data_o, ctrl_o, status_o;
  logic irq, scl_oe, sda_oe;
  logic slv_drv = 1'b0, arb_force = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | slv_drv | arb_force);
  int n_chk = 0, n_fail = 0;

  localparam logic [7:0] CB = 8'hC4;

  always #5 clk = ~clk;

  i2cm_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .iflg_w1c_i(w1c), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .data_o(data_o), .ctrl_o(ctrl_o),
    .status_o(status_o), .irq_o(irq), .scl_oe_o(scl_oe), .scl_i(scl_line),
    .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  // behavioural target
  int bitc = -2, byte_no = 0, nab;
  logic [7:0] rsh = '0, ack_mask = 8'hFF, rd_pat = '0, last_wr = '0;
  logic rd = 0, ten_s = 0, rd_done = 0, m_ack = 0, p_scl = 1, p_sda = 1, data_ok;

  function automatic logic [7:0] slv_byte(int j);
    return rd_pat + 8'(j * 37);
  endfunction

  always @(negedge clk) begin
    nab = ten_s ? 2 : 1;
    data_ok = rd && !rd_done && byte_no >= nab && ack_mask[0] && (!ten_s || ack_mask[1]);
    if (p_scl && scl_line && p_sda && !sda_line) begin
      bitc = -1; byte_no = 0; rd = 0; ten_s = 0; rd_done = 0; slv_drv = 0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      bitc = -2; slv_drv = 0;
    end else if (p_scl && !scl_line && bitc >= -1) begin
      if (bitc == 8) begin bitc = 0; byte_no++; end else bitc++;
      nab = ten_s ? 2 : 1;
      data_ok = rd && !rd_done && byte_no >= nab && ack_mask[0] && (!ten_s || ack_mask[1]);
      if (bitc == 8) slv_drv = !data_ok && (byte_no < 8 ? ack_mask[byte_no] : 1'b1);
      else if (data_ok) slv_drv = !slv_byte(byte_no - nab)[7 - bitc];
      else slv_drv = 0;
    end else if (!p_scl && scl_line && bitc >= 0) begin
      if (bitc < 8) rsh = {rsh[6:0], sda_line};
      else begin
        if (byte_no == 0) begin rd = rsh[0]; ten_s = (rsh[7:3] == 5'b11110); end
        if (data_ok) begin m_ack = !sda_line; if (sda_line) rd_done = 1; end
        else last_wr = rsh;
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ctl(input logic [7:0] b);
    wr(2'd1, w1c ? (b | 8'h08) : (b & 8'hF7));
  endtask

  task automatic wait_flag(input string req);
    int k = 0;
    while (!ctrl_o[3] && k < 4000) begin @(negedge clk); k++; end
    chk({req, " flag"}, {7'd0, ctrl_o[3]}, 8'd1);
  endtask

  task automatic do_stop();
    ctl(CB | 8'h10);
    repeat (40) @(negedge clk);
    chk("R9 status", status_o, 8'hF8);
    chk("R9 lines", {6'd0, scl_oe, sda_oe}, 8'd0);
  endtask

  task automatic xfer(input bit ten, input logic [9:0] a, input bit rdm, input int n);
    logic [7:0] d;
    ack_mask = 8'hFF; rd_pat = 8'($urandom);
    ctl(CB | 8'h20); wait_flag("R2");
    chk("R2 start", status_o, 8'h08);
    chk("R13 irq", {7'd0, irq}, 8'd1);
    wr(2'd0, ten ? (8'hF0 | {5'd0, a[9:8], 1'b0} | {7'd0, rdm}) : {a[6:0], rdm});
    ctl(CB); wait_flag("R3");
    chk("R3 addr", status_o, rdm ? 8'h40 : 8'h18);
    if (ten) begin
      wr(2'd0, a[7:0]); ctl(CB); wait_flag("R4");
      chk("R4 addr2", status_o, rdm ? 8'hE0 : 8'hD0);
      chk("R4 byte", last_wr, a[7:0]);
    end
    for (int i = 0; i < n; i++) begin
      if (!rdm) begin
        d = 8'($urandom); wr(2'd0, d); ctl(CB); wait_flag("R5");
        chk("R5 code", status_o, 8'h28);
        chk("R5 byte", last_wr, d);
      end else begin
        ctl((i == n - 1) ? (CB & 8'hFB) : CB); wait_flag("R6");
        chk("R6 code", status_o, (i == n - 1) ? 8'h58 : 8'h50);
        chk("R6 data", data_o, slv_byte(i));
        chk("R6 master ack", {7'd0, m_ack}, (i == n - 1) ? 8'd0 : 8'd1);
      end
    end
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 status", status_o, 8'hF8);
    chk("R1 ctrl", ctrl_o, 8'h00);
    chk("R1 irq/lines", {5'd0, irq, scl_oe, sda_oe}, 8'd0);
    // R2: START without ENABLE
    wr(2'd1, 8'h20);
    repeat (100) @(negedge clk);
    chk("R2 ignored", {6'd0, ctrl_o[3], scl_oe}, 8'd0);
    // directed transfers
    xfer(0, 10'h05A, 0, 2);
    xfer(0, 10'h033, 1, 3);
    xfer(1, 10'h2C5, 0, 1);
    xfer(1, 10'h19E, 1, 2);
    // R3 NACK write then read
    ack_mask = 8'hFE;
    ctl(CB | 8'h20); wait_flag("R3");
    wr(2'd0, 8'h90); ctl(CB); wait_flag("R3");
    chk("R3 nack wr", status_o, 8'h20);
    do_stop();
    ctl(CB | 8'h20); wait_flag("R3");
    wr(2'd0, 8'h91); ctl(CB); wait_flag("R3");
    chk("R3 nack rd", status_o, 8'h48);
    do_stop();
    // R4 NACK on second address byte
    ack_mask = 8'hFD;
    ctl(CB | 8'h20); wait_flag("R4");
    wr(2'd0, 8'hF2); ctl(CB); wait_flag("R4");
    wr(2'd0, 8'h44); ctl(CB); wait_flag("R4");
    chk("R4 nack", status_o, 8'hD8);
    do_stop();
    // R5 data NACK, R10 repeated start, R7 hold
    ctl(CB | 8'h20); wait_flag("R5");
    wr(2'd0, 8'h20); ctl(CB); wait_flag("R5");
    wr(2'd0, 8'h3C); ctl(CB); wait_flag("R5");
    chk("R5 nack", status_o, 8'h30);
    s = status_o;
    repeat (200) @(negedge clk);
    chk("R7 scl held", {7'd0, scl_oe}, 8'd1);
    chk("R7 status held", status_o, s);
    ack_mask = 8'hFF;
    ctl(CB | 8'h20); wait_flag("R10");
    chk("R10 restart", status_o, 8'h10);
    do_stop();
    // R8 clear polarity
    for (int m = 0; m < 2; m++) begin
      w1c = m[0];
      ctl(CB | 8'h20); wait_flag("R8");
      wr(2'd1, w1c ? CB : (CB | 8'h08));
      repeat (30) @(negedge clk);
      chk("R8 kept", {7'd0, ctrl_o[3]}, 8'd1);
      chk("R8 code", status_o, 8'h08);
      do_stop();
    end
    // R13 irq masked
    ctl(8'h64); wait_flag("R13");
    chk("R13 masked", {7'd0, irq}, 8'd0);
    do_stop();
    // R11 arbitration
    ctl(CB | 8'h20); wait_flag("R11");
    wr(2'd0, 8'h40); ctl(CB); wait_flag("R11");
    wr(2'd0, 8'hA0); arb_force = 1; ctl(CB); wait_flag("R11");
    chk("R11 code", status_o, 8'h38);
    chk("R11 lines", {6'd0, scl_oe, sda_oe}, 8'd0);
    arb_force = 0;
    ctl(CB);
    @(negedge clk);
    chk("R7 no status", status_o, 8'hF8);
    // R12 soft reset
    ctl(CB | 8'h20); wait_flag("R12");
    wr(2'd3, 8'h00);
    chk("R12 flag/status", status_o, 8'hF8);
    chk("R12 ctrl/lines", {ctrl_o[7:1], scl_oe}, 8'd0);
    // random transfers
    for (int t = 0; t < 24; t++) begin
      w1c = 1'($urandom);
      xfer(1'($urandom), 10'($urandom), 1'($urandom), 1 + int'($urandom % 4));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial void'($urandom(32'h1C2A));
endmodule